// File: doc/BRIEF.md
# Indirect-Window SPI Byte Engine

This block is a byte-serial SPI master that a host reaches through a three-port indirect I/O window. The host first loads an upper address byte and a lower address byte into two latches. A third port then reads or writes the internal register that the 16-bit address selects. Three internal registers run the serial link: a receive register, a transmit-command register and a control/status register. Two more registers are read-only and return identification constants.

A single write to the command register moves one byte out on MOSI and one byte in from MISO at the same time. Chip select is under software control: a control bit holds it low for as long as the host keeps it set, so an opcode, its address bytes and any data bytes all fall in one bus transaction. To read from a device, the host writes a dummy zero byte and then fetches the captured byte from the receive register once the busy flag has cleared. The serial clock is a division of the system clock, the link runs in mode 0, and bits go MSB first.

Top module: `spi_window_engine`

## Requirements
- R1: After reset the control register reads 0x00, cs_no is high and sclk_o is low.
- R2: A write to port 1 latches the upper address byte and a write to port 2 latches the lower address byte. Reading port 1 or port 2 returns the latched byte. Port 0 reads 0x00, and a write to port 0 changes nothing.
- R3: Port 3 accesses the register at the latched address. 0xFF00 reads HW_VER and 0xFF24 reads EDI_ID. Any address that is not mapped reads 0x00.
- R4: While bit 4 of the control register (0xFEAD) is 1, cs_no is low, including between consecutive byte transfers. Clearing bit 4 drives cs_no high.
- R5: A write to the command register (0xFEAC) shifts the written byte out MSB first in SPI mode 0. MOSI is stable at each rising SCLK edge, and there are exactly 8 rising edges. Each SCLK half period lasts DIV_HALF system cycles. The last falling edge comes 16*DIV_HALF cycles after the write edge, and the transfer ends with SCLK low.
- R6: Bits are sampled from MISO on the rising SCLK edges, MSB first. Once the transfer is done, the receive register (0xFEAB) holds the received byte.
- R7: Bit 1 of the control register reads 1 while a transfer is in progress, but only if bit 0 is 1. Otherwise bit 1 reads 0. Control bits 4, 3 and 0 read back as written.
- R8: A command write is ignored, and the transfer in progress continues unchanged, in either of two cases: control bit 3 (write enable) is 0, or a transfer is already running.
- R9: SCLK is low whenever no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe for the selected port |
| host_port_i | input | 2 | Window port select: 1 upper address, 2 lower address, 3 data |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Read byte of the selected port (combinational) |
| sclk_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | SPI master-out data |
| miso_i | input | 1 | SPI master-in data |
| cs_no | output | 1 | SPI chip select, active low |

## Verification
A command write takes effect at the clock edge that samples it, and busy rises on that same edge. The bench's first control-register read lands two cycles later, because the lower address byte has to be updated first. With the default DIV_HALF of 2, SCLK toggles every second cycle after the write edge. The bench therefore samples SCLK half a cycle before edge 32, where it must still be high, and half a cycle after edge 32, where it must be low. At that second point it also checks the captured MOSI byte and the count of rising edges. The received byte is read through the window only after that point. Window reads are combinational, so they are sampled one time unit after the port select changes, with no clock edge in between.

// File: rtl/spi_win_pkg.sv
package spi_win_pkg;
  localparam int BYTE_W = 8;

  localparam logic [15:0] ADDR_SPI_RX  = 16'hFEAB;
  localparam logic [15:0] ADDR_SPI_CMD = 16'hFEAC;
  localparam logic [15:0] ADDR_SPI_CFG = 16'hFEAD;
  localparam logic [15:0] ADDR_HW_VER  = 16'hFF00;
  localparam logic [15:0] ADDR_EDI_ID  = 16'hFF24;

  localparam int CFG_CS_BIT   = 4;
  localparam int CFG_WEN_BIT  = 3;
  localparam int CFG_BUSY_BIT = 1;
  localparam int CFG_CHK_BIT  = 0;

  localparam logic [1:0] PORT_HI   = 2'd1;
  localparam logic [1:0] PORT_LO   = 2'd2;
  localparam logic [1:0] PORT_DATA = 2'd3;

  typedef struct packed {
    logic cs_force;
    logic wr_en;
    logic busy_chk;
  } cfg_t;
endpackage

// File: rtl/spi_win_window.sv
module spi_win_window
  import spi_win_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_wr_i,
  input  logic [1:0]          host_port_i,
  input  logic [BYTE_W-1:0]   host_wdata_i,
  input  logic [BYTE_W-1:0]   reg_rdata_i,
  output logic [2*BYTE_W-1:0] addr_o,
  output logic                reg_wr_o,
  output logic [BYTE_W-1:0]   host_rdata_o
);
  logic [BYTE_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (host_wr_i) begin
      if (host_port_i == PORT_HI) hi_q <= host_wdata_i;
      if (host_port_i == PORT_LO) lo_q <= host_wdata_i;
    end
  end

  assign addr_o   = {hi_q, lo_q};
  assign reg_wr_o = host_wr_i && (host_port_i == PORT_DATA);

  always_comb begin
    case (host_port_i)
      PORT_HI:   host_rdata_o = hi_q;
      PORT_LO:   host_rdata_o = lo_q;
      PORT_DATA: host_rdata_o = reg_rdata_i;
      default:   host_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_win_regs.sv
module spi_win_regs
  import spi_win_pkg::*;
#(
  parameter logic [BYTE_W-1:0] HW_VER = 8'h3C,
  parameter logic [BYTE_W-1:0] EDI_ID = 8'h51
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*BYTE_W-1:0] addr_i,
  input  logic                reg_wr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic                busy_i,
  input  logic [BYTE_W-1:0]   rx_i,
  output cfg_t                cfg_o,
  output logic                cmd_wr_o,
  output logic [BYTE_W-1:0]   cmd_byte_o,
  output logic [BYTE_W-1:0]   rdata_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (reg_wr_i && addr_i == ADDR_SPI_CFG) begin
      cfg_q.cs_force <= wdata_i[CFG_CS_BIT];
      cfg_q.wr_en    <= wdata_i[CFG_WEN_BIT];
      cfg_q.busy_chk <= wdata_i[CFG_CHK_BIT];
    end
  end

  assign cfg_o      = cfg_q;
  assign cmd_wr_o   = reg_wr_i && (addr_i == ADDR_SPI_CMD);
  assign cmd_byte_o = wdata_i;

  logic [BYTE_W-1:0] cfg_view;
  always_comb begin
    cfg_view               = '0;
    cfg_view[CFG_CS_BIT]   = cfg_q.cs_force;
    cfg_view[CFG_WEN_BIT]  = cfg_q.wr_en;
    cfg_view[CFG_CHK_BIT]  = cfg_q.busy_chk;
    cfg_view[CFG_BUSY_BIT] = busy_i && cfg_q.busy_chk;
  end

  always_comb begin
    case (addr_i)
      ADDR_SPI_RX:  rdata_o = rx_i;
      ADDR_SPI_CFG: rdata_o = cfg_view;
      ADDR_HW_VER:  rdata_o = HW_VER;
      ADDR_EDI_ID:  rdata_o = EDI_ID;
      default:      rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_win_shifter.sv
module spi_win_shifter
  import spi_win_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] rx_o
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] tx_q, rx_q;
  logic [BIT_W-1:0]  bit_q;
  logic              busy_q, sclk_q, tick;

  // half-period tick; divider counter elided for the undivided variant
  generate
    if (DIV_HALF <= 1) begin : g_nodiv
      assign tick = busy_q;
    end else begin : g_div
      localparam int CNT_W = $clog2(DIV_HALF);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             cnt_q <= '0;
        else if (!busy_q)                        cnt_q <= '0;
        else if (cnt_q == CNT_W'(DIV_HALF - 1))  cnt_q <= '0;
        else                                     cnt_q <= cnt_q + 1'b1;
      end
      assign tick = busy_q && (cnt_q == CNT_W'(DIV_HALF - 1));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      bit_q  <= '0;
      tx_q   <= tx_i;
    end else if (tick) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx_q   <= {rx_q[BYTE_W-2:0], miso_i};
      end else begin
        sclk_q <= 1'b0;
        if (bit_q == BIT_W'(BYTE_W - 1)) begin
          busy_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
          tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[BYTE_W-1];
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_window_engine.sv
module spi_window_engine
  import spi_win_pkg::*;
#(
  parameter logic [7:0] HW_VER   = 8'h3C,
  parameter logic [7:0] EDI_ID   = 8'h51,
  parameter int         DIV_HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_wr_i,
  input  logic [1:0] host_port_i,
  input  logic [7:0] host_wdata_i,
  output logic [7:0] host_rdata_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i,
  output logic       cs_no
);
  logic [2*BYTE_W-1:0] addr;
  logic                reg_wr, cmd_wr, busy, start;
  logic [BYTE_W-1:0]   reg_rdata, cmd_byte, rx_byte;
  cfg_t                cfg;

  spi_win_window u_window (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_wr_i    (host_wr_i),
    .host_port_i  (host_port_i),
    .host_wdata_i (host_wdata_i),
    .reg_rdata_i  (reg_rdata),
    .addr_o       (addr),
    .reg_wr_o     (reg_wr),
    .host_rdata_o (host_rdata_o)
  );

  spi_win_regs #(.HW_VER(HW_VER), .EDI_ID(EDI_ID)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr),
    .reg_wr_i   (reg_wr),
    .wdata_i    (host_wdata_i),
    .busy_i     (busy),
    .rx_i       (rx_byte),
    .cfg_o      (cfg),
    .cmd_wr_o   (cmd_wr),
    .cmd_byte_o (cmd_byte),
    .rdata_o    (reg_rdata)
  );

  // a start needs write enable and an idle shifter
  assign start = cmd_wr && cfg.wr_en && !busy;

  spi_win_shifter #(.DIV_HALF(DIV_HALF)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .tx_i    (cmd_byte),
    .miso_i  (miso_i),
    .busy_o  (busy),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .rx_o    (rx_byte)
  );

  assign cs_no = ~cfg.cs_force;
endmodule

// File: rtl/spi_win_chk.sv
module spi_win_chk
  import spi_win_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic sclk_i,
  input logic cmd_wr_i,
  input logic wr_en_i
);
  localparam int EC_W = $clog2(BYTE_W) + 1;

  logic            sclk_d;
  logic [EC_W-1:0] rise_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk_i;
      if (!busy_i)                rise_cnt <= '0;
      else if (sclk_i && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  assert_idle_sclk_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !sclk_i);

  assert_start_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(cmd_wr_i && wr_en_i));

  assert_end_sclk_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> !sclk_i);

  assert_eight_edges_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> rise_cnt == EC_W'(BYTE_W));

  assert_busy_spans_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |=> busy_i);
endmodule

bind spi_window_engine spi_win_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_i   (busy),
  .sclk_i   (sclk_o),
  .cmd_wr_i (cmd_wr),
  .wr_en_i  (cfg.wr_en)
);

// File: tb/tb_spi_window_engine.sv
module tb_spi_window_engine;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       host_wr_i = 1'b0;
  logic [1:0] host_port_i = 2'd0;
  logic [7:0] host_wdata_i = 8'h00;
  logic [7:0] host_rdata_o;
  logic       sclk_o, mosi_o, miso_i, cs_no;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  spi_window_engine dut (
    .clk_i, .rst_ni, .host_wr_i, .host_port_i, .host_wdata_i,
    .host_rdata_o, .sclk_o, .mosi_o, .miso_i, .cs_no
  );

  // device model: mode 0 slave, counters cleared by mon_clr
  logic       mon_clr = 1'b0;
  logic [7:0] slv_byte = 8'h00;
  logic [7:0] mosi_cap;
  logic [3:0] rise_cnt, fall_cnt;

  always @(posedge sclk_o or posedge mon_clr) begin
    if (mon_clr) begin
      mosi_cap <= 8'h00;
      rise_cnt <= 4'd0;
    end else begin
      mosi_cap <= {mosi_cap[6:0], mosi_o};
      rise_cnt <= rise_cnt + 4'd1;
    end
  end

  always @(negedge sclk_o or posedge mon_clr) begin
    if (mon_clr) fall_cnt <= 4'd0;
    else         fall_cnt <= fall_cnt + 4'd1;
  end

  assign miso_i = (fall_cnt < 4'd8) ? slv_byte[3'(4'd7 - fall_cnt)] : 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk_i);
    host_port_i  = p;
    host_wdata_i = d;
    host_wr_i    = 1'b1;
    @(negedge clk_i);
    host_wr_i    = 1'b0;
  endtask

  task automatic read_port(input logic [1:0] p, output logic [7:0] d);
    host_port_i = p;
    #1 d = host_rdata_o;
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
    host_write(2'd1, a[15:8]);
    host_write(2'd2, a[7:0]);
    host_write(2'd3, d);
  endtask

  task automatic reg_read(input logic [15:0] a, output logic [7:0] d);
    host_write(2'd1, a[15:8]);
    host_write(2'd2, a[7:0]);
    read_port(2'd3, d);
  endtask

  task automatic clear_mon();
    mon_clr = 1'b1;
    #1 mon_clr = 1'b0;
  endtask

  // {tx byte, device reply}
  localparam logic [15:0] VEC [6] = '{
    16'hA53C, 16'h00FF, 16'hFF00, 16'h817E, 16'h5AC3, 16'h0180
  };

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    clear_mon();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check("R1 cs_no", 32'(cs_no), 32'h1);
    check("R1 sclk", 32'(sclk_o), 32'h0);
    reg_read(16'hFEAD, d);
    check("R1 cfg", 32'(d), 32'h00);

    // R2 address latches
    host_write(2'd1, 8'h12);
    host_write(2'd2, 8'h34);
    read_port(2'd1, d); check("R2 hi", 32'(d), 32'h12);
    read_port(2'd2, d); check("R2 lo", 32'(d), 32'h34);
    read_port(2'd0, d); check("R2 port0 read", 32'(d), 32'h00);
    host_write(2'd0, 8'hEE);
    read_port(2'd1, d); check("R2 port0 write ignored hi", 32'(d), 32'h12);
    read_port(2'd2, d); check("R2 port0 write ignored lo", 32'(d), 32'h34);

    // R3 identification and unmapped
    read_port(2'd3, d); check("R3 unmapped", 32'(d), 32'h00);
    reg_read(16'hFF00, d); check("R3 hw ver", 32'(d), 32'h3C);
    reg_read(16'hFF24, d); check("R3 edi id", 32'(d), 32'h51);

    // R8 write enable clear: command ignored
    reg_write(16'hFEAD, 8'h11);
    check("R4 cs low", 32'(cs_no), 32'h0);
    clear_mon();
    reg_write(16'hFEAC, 8'hA5);
    repeat (40) @(negedge clk_i);
    check("R8 no edges when disabled", 32'(rise_cnt), 32'h0);
    reg_read(16'hFEAD, d);
    check("R8 idle after disabled cmd", 32'(d), 32'h11);

    // R5 R6 R4 vector walk with cs held
    reg_write(16'hFEAD, 8'h19);
    for (int i = 0; i < 6; i++) begin
      slv_byte = VEC[i][7:0];
      clear_mon();
      reg_write(16'hFEAC, VEC[i][15:8]);
      repeat (31) @(negedge clk_i);
      check("R5 last high phase", 32'(sclk_o), 32'h1);
      @(negedge clk_i);
      check("R5 sclk low at end", 32'(sclk_o), 32'h0);
      check("R5 rising edges", 32'(rise_cnt), 32'h8);
      check("R5 mosi byte", 32'(mosi_cap), 32'(VEC[i][15:8]));
      check("R4 cs held", 32'(cs_no), 32'h0);
      reg_read(16'hFEAB, d);
      check("R6 rx byte", 32'(d), 32'(VEC[i][7:0]));
    end

    // R7 busy visible, R8 write while busy ignored
    slv_byte = 8'h96;
    clear_mon();
    reg_write(16'hFEAC, 8'h33);
    host_write(2'd2, 8'hAD);
    read_port(2'd3, d);
    check("R7 busy flag", 32'(d), 32'h1B);
    host_write(2'd2, 8'hAC);
    host_write(2'd3, 8'hCC);
    repeat (40) @(negedge clk_i);
    check("R8 busy cmd ignored mosi", 32'(mosi_cap), 32'h33);
    check("R8 busy cmd ignored edges", 32'(rise_cnt), 32'h8);
    reg_read(16'hFEAB, d);
    check("R8 rx unchanged", 32'(d), 32'h96);
    reg_read(16'hFEAD, d);
    check("R7 busy cleared", 32'(d), 32'h19);

    // R7 busy hidden when check bit clear
    reg_write(16'hFEAD, 8'h18);
    reg_write(16'hFEAC, 8'h0F);
    host_write(2'd2, 8'hAD);
    read_port(2'd3, d);
    check("R7 busy masked", 32'(d), 32'h18);
    repeat (40) @(negedge clk_i);

    // R4 release, R9 idle clock
    reg_write(16'hFEAD, 8'h08);
    check("R4 cs released", 32'(cs_no), 32'h1);
    check("R9 sclk idle", 32'(sclk_o), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule